// File: doc/BRIEF.md
# Speculative Load Alias Table

This block tracks loads that software has scheduled ahead of stores that might write the same bytes. When such a load executes, it records the destination register tag together with the bytes it read. Every committed store is then compared in parallel against all tracked entries, and any entry whose bytes overlap the store is removed. Before the loaded value is used, a check presents the register tag. A hit means no store has touched those bytes since the load. A miss means the load must be repeated or recovery code must run.

The table has 32 entries arranged as 16 sets of two ways. The set is chosen by the low four bits of the 7-bit register tag. The remaining three tag bits, the 8-byte block address and an 8-bit byte mask are kept in each way. Losing an entry through eviction, a store, a clearing check or a flush is always safe, because it only forces recovery. A flush input empties the whole table in one cycle, for use on a context switch.

Top module: `alias_load_table`

## Requirements
- R1: After synchronous active-low reset, a check of any of the 128 register tags reports a miss.
- R2: A load to tag T causes a later check of T to hit. The set index is T[3:0] and T[6:4] is stored per way, so a tag that shares the index but differs in T[6:4] still misses.
- R3: Two tags with the same index occupy both ways of the set. A third such tag replaces the least recently allocated way, and a check of the replaced tag misses.
- R4: A load to a tag that is already held rewrites that same way in place, with the new address and size. This rewrite counts as the way's most recent allocation, and the other way of the set is kept.
- R5: A store removes every entry whose bytes overlap its own. Bytes overlap when both accesses fall in the same 8-byte block, taken as address bits [31:3], and their byte masks intersect. The size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes, starting at address bits [2:0]. Accesses are naturally aligned.
- R6: A store that lies in a different 8-byte block, or that covers disjoint bytes of the same block, leaves the entry in place.
- R7: When a load and a store arrive in the same cycle, the load is inserted first. The new entry is therefore removed if the store overlaps it and kept otherwise.
- R8: The check result is combinational and appears in the cycle the check is presented. It is low whenever chk_valid is low.
- R9: A check with chk_clear set reports its result in that cycle, and the checked entry is gone from the next cycle on. The other way of the same set is not affected.
- R10: A flush pulse empties the table in one cycle. This includes a load that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_all | input | 1 | Invalidate every entry |
| ld_valid | input | 1 | Advanced load present |
| ld_tag | input | 7 | Destination register tag of the load |
| ld_addr | input | 32 | Byte address of the load |
| ld_size | input | 2 | Load size code (0=1B, 1=2B, 2=4B, 3=8B) |
| st_valid | input | 1 | Committed store present |
| st_addr | input | 32 | Byte address of the store |
| st_size | input | 2 | Store size code |
| chk_valid | input | 1 | Check request present |
| chk_tag | input | 7 | Register tag to check |
| chk_clear | input | 1 | Invalidate the checked entry after this cycle |
| chk_hit | output | 1 | Entry for chk_tag is still valid |

## Verification
The assertions assume that accesses are naturally aligned, so that every byte mask fits inside one 8-byte block. They also assume that each cycle carries at most one load, one store and one check. The uniqueness assertion takes for granted that a tag only ever enters the table through the load port. The bench drives only aligned offsets for every size and uses one operation per port per cycle. It sweeps every aligned load placement against every aligned store placement, and computes the expected survival from byte ranges.

// File: rtl/alt_pkg.sv
// Package: shared constants and the access-size encoding for the alias table.
// Assumes an 8-byte block granule for overlap comparison.
package alt_pkg;
    localparam int BLK_OFS_W = 3;
    localparam int MASK_W    = 8;

    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } acc_size_e;
endpackage

// File: rtl/alt_decode.sv
// Module: splits a byte address into its 8-byte block number and a byte mask
// covering the accessed bytes. Assumes naturally aligned accesses; any bytes
// that would spill past the block are dropped.
module alt_decode
    import alt_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int LINE_W = ADDR_W - BLK_OFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [LINE_W-1:0] line,
    output logic [MASK_W-1:0] mask
);
    logic [MASK_W-1:0] span;

    // Purpose: derive the byte span for the size code, then shift to the offset.
    always_comb begin
        case (acc_size_e'(size))
            SZ_B1:   span = 8'h01;
            SZ_B2:   span = 8'h03;
            SZ_B4:   span = 8'h0F;
            default: span = 8'hFF;
        endcase
        mask = span << addr[BLK_OFS_W-1:0];
        line = addr[ADDR_W-1:BLK_OFS_W];
    end
endmodule

// File: rtl/alt_set.sv
// Module: one two-way set of the alias table. It holds the upper tag bits,
// the block number and the byte mask for each way, plus one replacement bit
// that names the least recently allocated way. Assumes that a tag enters
// only through the load port, so at most one way holds a given tag.
// Update order in a cycle: check-clear, load insert, store kill, flush.
module alt_set
    import alt_pkg::*;
#(
    parameter int HI_W   = 3,
    parameter int LINE_W = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              ld_en,
    input  logic [HI_W-1:0]   ld_hi,
    input  logic [LINE_W-1:0] ld_line,
    input  logic [MASK_W-1:0] ld_mask,
    input  logic              st_en,
    input  logic [LINE_W-1:0] st_line,
    input  logic [MASK_W-1:0] st_mask,
    input  logic              chk_en,
    input  logic [HI_W-1:0]   chk_hi,
    input  logic              chk_clear,
    output logic              chk_hit
);
    logic [1:0]                    vld_q, vld_n;
    logic [1:0][HI_W-1:0]          hi_q, hi_n;
    logic [1:0][LINE_W-1:0]        line_q, line_n;
    logic [1:0][MASK_W-1:0]        mask_q, mask_n;
    logic                          lru_q, lru_n;
    logic [1:0]                    ld_match, chk_match;
    logic                          victim;
    logic                          ld_st_ov;

    // Purpose: tag comparison of each way against the load and the check.
    always_comb begin
        for (int w = 0; w < 2; w++) begin
            ld_match[w]  = vld_q[w] && (hi_q[w] == ld_hi);
            chk_match[w] = vld_q[w] && (hi_q[w] == chk_hi);
        end
    end

    // Purpose: choose the way a load writes: same tag, then empty, then oldest.
    always_comb begin
        if (ld_match[0])      victim = 1'b0;
        else if (ld_match[1]) victim = 1'b1;
        else if (!vld_q[0])   victim = 1'b0;
        else if (!vld_q[1])   victim = 1'b1;
        else                  victim = lru_q;
    end

    assign chk_hit  = chk_en && (|chk_match);
    assign ld_st_ov = st_en && (ld_line == st_line) && (|(ld_mask & st_mask));

    // Purpose: next state in the fixed order clear, insert, store kill, flush.
    always_comb begin
        vld_n  = vld_q;
        hi_n   = hi_q;
        line_n = line_q;
        mask_n = mask_q;
        lru_n  = lru_q;
        for (int w = 0; w < 2; w++) begin
            if (chk_en && chk_clear && chk_match[w]) vld_n[w] = 1'b0;
        end
        if (ld_en) begin
            vld_n[victim]  = 1'b1;
            hi_n[victim]   = ld_hi;
            line_n[victim] = ld_line;
            mask_n[victim] = ld_mask;
            lru_n          = ~victim;
        end
        for (int w = 0; w < 2; w++) begin
            if (st_en && vld_n[w] && (line_n[w] == st_line) && (|(mask_n[w] & st_mask)))
                vld_n[w] = 1'b0;
        end
        if (flush) vld_n = '0;
    end

    // Purpose: state registers; only the valid and replacement bits are reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            lru_q <= 1'b0;
        end else begin
            vld_q <= vld_n;
            lru_q <= lru_n;
        end
        hi_q   <= hi_n;
        line_q <= line_n;
        mask_q <= mask_n;
    end

    a_r4_single_entry_per_tag: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld_q == 2'b11 && hi_q[0] == hi_q[1]));

    a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !flush && !ld_st_ov) |=>
        ((vld_q[0] && hi_q[0] == $past(ld_hi)) || (vld_q[1] && hi_q[1] == $past(ld_hi))));

    a_r5_store_leaves_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |=>
        !((vld_q[0] && line_q[0] == $past(st_line) && (|(mask_q[0] & $past(st_mask)))) ||
          (vld_q[1] && line_q[1] == $past(st_line) && (|(mask_q[1] & $past(st_mask))))));

    a_r9_clear_removes: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && chk_clear && !(ld_en && ld_hi == chk_hi)) |=>
        !((vld_q[0] && hi_q[0] == $past(chk_hi)) || (vld_q[1] && hi_q[1] == $past(chk_hi))));

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_q == 2'b00));
endmodule

// File: rtl/alias_load_table.sv
// Module: top of the speculative load alias table. It decodes the load and
// store addresses, steers the load and the check to the set picked by the
// low tag bits, broadcasts the store to every set and ORs the set hits.
// Assumes at most one load, one store and one check per cycle.
module alias_load_table
    import alt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 7,
    parameter int IDX_W  = 4,
    localparam int SETS   = 1 << IDX_W,
    localparam int HI_W   = TAG_W - IDX_W,
    localparam int LINE_W = ADDR_W - BLK_OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_all,
    input  logic              ld_valid,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_size,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic              chk_valid,
    input  logic [TAG_W-1:0]  chk_tag,
    input  logic              chk_clear,
    output logic              chk_hit
);
    logic [LINE_W-1:0] ld_line, st_line;
    logic [MASK_W-1:0] ld_mask, st_mask;
    logic [SETS-1:0]   set_ld, set_chk, set_hit;

    alt_decode #(.ADDR_W(ADDR_W)) u_ld_dec (
        .addr(ld_addr), .size(ld_size), .line(ld_line), .mask(ld_mask));

    alt_decode #(.ADDR_W(ADDR_W)) u_st_dec (
        .addr(st_addr), .size(st_size), .line(st_line), .mask(st_mask));

    for (genvar s = 0; s < SETS; s++) begin : g_set
        assign set_ld[s]  = ld_valid  && (ld_tag[IDX_W-1:0]  == IDX_W'(s));
        assign set_chk[s] = chk_valid && (chk_tag[IDX_W-1:0] == IDX_W'(s));

        alt_set #(.HI_W(HI_W), .LINE_W(LINE_W)) u_set (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush_all),
            .ld_en    (set_ld[s]),
            .ld_hi    (ld_tag[TAG_W-1:IDX_W]),
            .ld_line  (ld_line),
            .ld_mask  (ld_mask),
            .st_en    (st_valid),
            .st_line  (st_line),
            .st_mask  (st_mask),
            .chk_en   (set_chk[s]),
            .chk_hi   (chk_tag[TAG_W-1:IDX_W]),
            .chk_clear(chk_clear),
            .chk_hit  (set_hit[s])
        );
    end

    assign chk_hit = |set_hit;

    a_r8_single_set_answers: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_hit));

    a_r8_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |-> !chk_hit);
endmodule

// File: tb/alias_load_table_tb.sv
// Bench: directed replacement scenarios plus a full sweep of aligned load and
// store placements. Expected overlap comes from byte-range arithmetic.
module alias_load_table_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_all = 1'b0;
    logic        ld_valid = 1'b0;
    logic [6:0]  ld_tag = '0;
    logic [31:0] ld_addr = '0;
    logic [1:0]  ld_size = '0;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0;
    logic [1:0]  st_size = '0;
    logic        chk_valid = 1'b0;
    logic [6:0]  chk_tag = '0;
    logic        chk_clear = 1'b0;
    logic        chk_hit;
    int          n_checks = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    alias_load_table u_dut (
        .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
        .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr), .ld_size(ld_size),
        .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
        .chk_valid(chk_valid), .chk_tag(chk_tag), .chk_clear(chk_clear),
        .chk_hit(chk_hit));

    task automatic report_end();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // One clock edge, then drop all strobes just after it.
    task automatic cyc();
        @(posedge clk);
        #1;
        ld_valid = 0; st_valid = 0; chk_valid = 0; chk_clear = 0; flush_all = 0;
    endtask

    task automatic set_load(input logic [6:0] t, input logic [31:0] a, input logic [1:0] sz);
        ld_valid = 1; ld_tag = t; ld_addr = a; ld_size = sz;
    endtask

    task automatic set_store(input logic [31:0] a, input logic [1:0] sz);
        st_valid = 1; st_addr = a; st_size = sz;
    endtask

    task automatic do_flush();
        flush_all = 1; cyc();
    endtask

    task automatic expect_tag(input logic [6:0] t, input logic exp, input string req);
        chk_valid = 1; chk_tag = t; chk_clear = 0;
        #2;
        n_checks++;
        if (chk_hit !== exp) begin
            n_fail++;
            $display("FAIL %s tag=%0d chk_hit=%b expected=%b", req, t, chk_hit, exp);
        end
        chk_valid = 0;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report_end();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: empty after reset
        for (int t = 0; t < 128; t++) expect_tag(7'(t), 1'b0, "R1");

        // R2: insert and index / upper-tag separation
        set_load(7'd5, 32'h100, 2'd3); cyc();
        expect_tag(7'd5, 1'b1, "R2");
        expect_tag(7'd21, 1'b0, "R2");
        expect_tag(7'd6, 1'b0, "R2");

        // R3: oldest-allocation replacement in set 5
        set_load(7'd21, 32'h200, 2'd3); cyc();
        expect_tag(7'd5, 1'b1, "R3");
        expect_tag(7'd21, 1'b1, "R3");
        set_load(7'd37, 32'h300, 2'd3); cyc();
        expect_tag(7'd5, 1'b0, "R3");
        expect_tag(7'd21, 1'b1, "R3");
        expect_tag(7'd37, 1'b1, "R3");
        set_load(7'd53, 32'h400, 2'd3); cyc();
        expect_tag(7'd21, 1'b0, "R3");
        expect_tag(7'd37, 1'b1, "R3");
        expect_tag(7'd53, 1'b1, "R3");

        // R4: reload in place refreshes age; new address replaces old
        set_load(7'd37, 32'h500, 2'd3); cyc();
        expect_tag(7'd53, 1'b1, "R4");
        set_load(7'd69, 32'h600, 2'd3); cyc();
        expect_tag(7'd53, 1'b0, "R4");
        expect_tag(7'd37, 1'b1, "R4");
        expect_tag(7'd69, 1'b1, "R4");
        set_store(32'h300, 2'd3); cyc();
        expect_tag(7'd37, 1'b1, "R4");
        set_store(32'h500, 2'd0); cyc();
        expect_tag(7'd37, 1'b0, "R4");
        expect_tag(7'd69, 1'b1, "R4");

        // R8: idle check port reports no hit; result is same-cycle
        chk_valid = 0; chk_tag = 7'd69; #2;
        n_checks++;
        if (chk_hit !== 1'b0) begin
            n_fail++;
            $display("FAIL R8 idle chk_hit=%b expected=0", chk_hit);
        end
        expect_tag(7'd69, 1'b1, "R8");

        // R9: clearing check, other way survives
        set_load(7'd85, 32'h700, 2'd3); cyc();
        chk_valid = 1; chk_tag = 7'd85; chk_clear = 1; #2;
        n_checks++;
        if (chk_hit !== 1'b1) begin
            n_fail++;
            $display("FAIL R9 clearing check chk_hit=%b expected=1", chk_hit);
        end
        cyc();
        expect_tag(7'd85, 1'b0, "R9");
        expect_tag(7'd69, 1'b1, "R9");

        // R10: flush empties, including a same-cycle load
        set_load(7'd1, 32'h800, 2'd2); cyc();
        set_load(7'd2, 32'h900, 2'd2); flush_all = 1; cyc();
        expect_tag(7'd1, 1'b0, "R10");
        expect_tag(7'd2, 1'b0, "R10");
        expect_tag(7'd69, 1'b0, "R10");

        // R7: same-cycle load and store
        set_load(7'd10, 32'h1000, 2'd2); set_store(32'h1002, 2'd1); cyc();
        expect_tag(7'd10, 1'b0, "R7");
        set_load(7'd11, 32'h1000, 2'd2); set_store(32'h1004, 2'd2); cyc();
        expect_tag(7'd11, 1'b1, "R7");

        // R6: same bytes in another block leave the entry
        set_load(7'd12, 32'h2000, 2'd3); cyc();
        set_store(32'h2008, 2'd3); cyc();
        expect_tag(7'd12, 1'b1, "R6");

        // R5 / R6: every aligned load placement against every aligned store placement
        for (int ls = 0; ls < 4; ls++) begin
            for (int lo = 0; lo < 8; lo += (1 << ls)) begin
                for (int ss = 0; ss < 4; ss++) begin
                    for (int so = 0; so < 8; so += (1 << ss)) begin
                        int  lend;
                        int  send;
                        logic ov;
                        lend = lo + (1 << ls);
                        send = so + (1 << ss);
                        ov = (lo < send) && (so < lend);
                        do_flush();
                        set_load(7'd9, 32'h4000 + 32'(lo), 2'(ls)); cyc();
                        set_store(32'h4000 + 32'(so), 2'(ss)); cyc();
                        expect_tag(7'd9, !ov, ov ? "R5" : "R6");
                    end
                end
            end
        end

        report_end();
    end
endmodule